// File: doc/BRIEF.md
# Memory Controller Event Counter Unit

This block watches a DRAM controller and counts what it does. It has a group of counters behind a small register port. Counter 0 is the reference and counts clock cycles only. Each of the other counters counts one event. An 8-bit select code picks that event from a vector of single-cycle event pulses. Two further select codes count read or write transactions, but only those whose transaction ID passes a shared match-and-mask filter.

The cycle counter governs the whole unit. A run-control state machine has three states. IDLE: the cycle counter is disabled and nothing counts. RUN: every enabled counter counts. FROZEN: the cycle counter has wrapped and everything holds. The transitions are:

- IDLE to RUN when counter 0's control register is written with enable set.
- RUN to IDLE when that register is written with enable clear.
- RUN to FROZEN when the cycle counter wraps.
- FROZEN to RUN or to IDLE on any write to counter 0's control register, depending on the enable bit written.

The interrupt is the cycle counter's sticky overflow flag. Event counters wrap silently. Software reads the counters on the interrupt, then re-arms the unit.

Top module: `mc_evt_monitor`

## Requirements
- R1: After reset, every control, value and filter register reads 0, every other offset reads 0, the run state is IDLE and irq is low.
- R2: Register map (byte offsets):
  - The control register of counter n is at 4*n. Bit 0 is the sticky overflow flag. Bit 1 is clear, which always reads 0. Bit 2 is enable. Bits 31:24 are the select code.
  - The value of counter n is at 0x20+4*n, zero-extended.
  - The filter is at 0x30, with the match ID in bits 15:0 and the don't-care mask in bits 31:16.
  - Writes apply at the clock edge. Reads are combinational.
- R3: Counter 0 counts once per clock while enabled in the RUN state. A select code written to counter 0 is discarded, and its select field reads 0.
- R4: Counters 1 to 3 count cycles in which evt_pulse[sel] is high, while they are enabled and the state is RUN. A select code at or above the event vector width, other than 0x41 and 0x42, counts nothing.
- R5: Code 0x41 counts cycles with txn_rd_valid high and a matching txn_rd_id. Code 0x42 does the same for the write channel. An ID matches when ((id XOR filter_id) AND NOT mask) is zero, so a mask bit of 1 is don't-care.
- R6: A counter among 1 to 3 that wraps goes to 0, sets its overflow flag and keeps counting, and irq stays unchanged.
- R7: When counter 0 wraps, it goes to 0, its overflow flag and irq rise, and the state becomes FROZEN. All counters then hold until counter 0's control register is written, which clears the flag and irq.
- R8: Writing counter 0's control register with enable clear halts all counters, which keep their values. Enabling it again lets them resume from those values.
- R9: A control write clears that counter's overflow flag. It zeroes the counter if the clear bit is set, or if enable goes from 0 to 1. A counter does not increment in the cycle of a write to its own control register.
- R10: The run state follows exactly the IDLE, RUN and FROZEN transitions listed above, and a control write takes priority over a wrap in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| evt_pulse | input | NUM_EVT | Single-cycle event pulses, indexed by select code |
| txn_rd_valid | input | 1 | Read transaction strobe |
| txn_rd_id | input | 16 | Read transaction ID |
| txn_wr_valid | input | 1 | Write transaction strobe |
| txn_wr_id | input | 16 | Write transaction ID |
| irq | output | 1 | Level interrupt, equal to counter 0's overflow flag |

## Verification
A wrong run state shows at the ports on the very next clock. If the state is stuck in RUN past a wrap, counter 0 reads 1, 2 and so on instead of holding at 0. If it falls into FROZEN or IDLE early, the event counters come up short by exactly the number of cycles lost. A wrong filter or select decode shows as an event count that differs from the arithmetic sum of the stimulus the moment the value register is read. A lost sticky flag shows in the control readback and in irq one cycle after the wrap. The bench uses 8-bit counters, so both kinds of wrap are reached within a few hundred cycles.

// File: rtl/mcm_pkg.sv
`timescale 1ns/1ps
package mcm_pkg;
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_RUN    = 2'd1,
        RS_FROZEN = 2'd2
    } run_state_t;

    localparam logic [7:0] CODE_RD_FILT = 8'h41;
    localparam logic [7:0] CODE_WR_FILT = 8'h42;
    localparam int         VAL_BASE     = 32'h20;
    localparam int         FILT_OFS     = 32'h30;
    localparam int         BIT_OVF      = 0;
    localparam int         BIT_CLR      = 1;
    localparam int         BIT_EN       = 2;
    localparam int         SEL_LSB      = 24;
endpackage

// File: rtl/mcm_id_filter.sv
`timescale 1ns/1ps
module mcm_id_filter #(
    parameter int ID_W = 16
) (
    input  logic            rd_valid,
    input  logic [ID_W-1:0] rd_id,
    input  logic            wr_valid,
    input  logic [ID_W-1:0] wr_id,
    input  logic [ID_W-1:0] match_id,
    input  logic [ID_W-1:0] dont_care,
    output logic            rd_hit,
    output logic            wr_hit
);
    always_comb begin
        rd_hit = rd_valid && (((rd_id ^ match_id) & ~dont_care) == '0);
        wr_hit = wr_valid && (((wr_id ^ match_id) & ~dont_care) == '0);
    end
endmodule

// File: rtl/mcm_evt_mux.sv
`timescale 1ns/1ps
module mcm_evt_mux #(
    parameter int NUM_EVT = 64
) (
    input  logic [7:0]         sel,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               rd_hit,
    input  logic               wr_hit,
    output logic               hit
);
    import mcm_pkg::*;
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    always_comb begin
        if (sel == CODE_RD_FILT)
            hit = rd_hit;
        else if (sel == CODE_WR_FILT)
            hit = wr_hit;
        else if (32'(sel) < NUM_EVT)
            hit = evt[sel[IDX_W-1:0]];
        else
            hit = 1'b0;
    end
endmodule

// File: rtl/mcm_counter.sv
`timescale 1ns/1ps
module mcm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             wr_en_bit,
    input  logic             wr_clr_bit,
    input  logic [7:0]       wr_sel,
    input  logic             gate,
    input  logic             hit,
    output logic [CNT_W-1:0] value,
    output logic             en,
    output logic [7:0]       sel,
    output logic             ovf
);
    logic count_now;
    assign count_now = gate && en && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            en    <= 1'b0;
            sel   <= '0;
            ovf   <= 1'b0;
        end else if (ctl_wr) begin
            en  <= wr_en_bit;
            sel <= wr_sel;
            ovf <= 1'b0;
            if (wr_clr_bit || (wr_en_bit && !en))
                value <= '0;
        end else if (count_now) begin
            value <= value + 1'b1;
            if (&value)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/mcm_run_fsm.sv
`timescale 1ns/1ps
module mcm_run_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl0_wr,
    input  logic                ctl0_en,
    input  logic                c0_wrap,
    output mcm_pkg::run_state_t state
);
    import mcm_pkg::*;
    run_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RS_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE: begin
                if (ctl0_wr && ctl0_en)
                    nxt = RS_RUN;
            end
            RS_RUN: begin
                if (ctl0_wr)
                    nxt = ctl0_en ? RS_RUN : RS_IDLE;
                else if (c0_wrap)
                    nxt = RS_FROZEN;
            end
            RS_FROZEN: begin
                if (ctl0_wr)
                    nxt = ctl0_en ? RS_RUN : RS_IDLE;
            end
            default: nxt = RS_IDLE;
        endcase
    end
endmodule

// File: rtl/mc_evt_monitor.sv
`timescale 1ns/1ps
module mc_evt_monitor #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 64,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic               txn_rd_valid,
    input  logic [ID_W-1:0]    txn_rd_id,
    input  logic               txn_wr_valid,
    input  logic [ID_W-1:0]    txn_wr_id,
    output logic               irq
);
    import mcm_pkg::*;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0][7:0]       cnt_sel;
    logic [NUM_CNT-1:0]            cnt_en;
    logic [NUM_CNT-1:0]            cnt_ovf;
    logic [NUM_CNT-1:0]            cnt_hit;
    logic [NUM_CNT-1:0]            ctl_wr;
    logic [ID_W-1:0]               filt_id;
    logic [ID_W-1:0]               filt_mask;
    logic                          rd_hit;
    logic                          wr_hit;
    logic                          count_gate;
    logic                          c0_wrap;
    run_state_t                    run_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_id   <= '0;
            filt_mask <= '0;
        end else if (reg_wr_en && reg_addr == ADDR_W'(FILT_OFS)) begin
            filt_id   <= reg_wdata[ID_W-1:0];
            filt_mask <= reg_wdata[16 +: ID_W];
        end
    end

    mcm_id_filter #(.ID_W(ID_W)) u_filter (
        .rd_valid (txn_rd_valid),
        .rd_id    (txn_rd_id),
        .wr_valid (txn_wr_valid),
        .wr_id    (txn_wr_id),
        .match_id (filt_id),
        .dont_care(filt_mask),
        .rd_hit   (rd_hit),
        .wr_hit   (wr_hit)
    );

    assign count_gate = (run_state == RS_RUN);
    assign c0_wrap    = count_gate && cnt_en[0] && (&cnt_val[0]) && !ctl_wr[0];

    mcm_run_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl0_wr(ctl_wr[0]),
        .ctl0_en(reg_wdata[BIT_EN]),
        .c0_wrap(c0_wrap),
        .state  (run_state)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic [7:0] sel_in;
        assign ctl_wr[n] = reg_wr_en && (reg_addr == ADDR_W'(4 * n));

        if (n == 0) begin : g_cycle
            assign cnt_hit[n] = 1'b1;
            assign sel_in     = 8'h00;
        end else begin : g_event
            assign sel_in = reg_wdata[SEL_LSB +: 8];
            mcm_evt_mux #(.NUM_EVT(NUM_EVT)) u_mux (
                .sel   (cnt_sel[n]),
                .evt   (evt_pulse),
                .rd_hit(rd_hit),
                .wr_hit(wr_hit),
                .hit   (cnt_hit[n])
            );
        end

        mcm_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_wr[n]),
            .wr_en_bit (reg_wdata[BIT_EN]),
            .wr_clr_bit(reg_wdata[BIT_CLR]),
            .wr_sel    (sel_in),
            .gate      (count_gate),
            .hit       (cnt_hit[n]),
            .value     (cnt_val[n]),
            .en        (cnt_en[n]),
            .sel       (cnt_sel[n]),
            .ovf       (cnt_ovf[n])
        );
    end

    assign irq = cnt_ovf[0];

    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr == ADDR_W'(4 * n))
                reg_rdata = {cnt_sel[n], 21'b0, cnt_en[n], 1'b0, cnt_ovf[n]};
            if (reg_addr == ADDR_W'(VAL_BASE + 4 * n))
                reg_rdata = 32'(cnt_val[n]);
        end
        if (reg_addr == ADDR_W'(FILT_OFS))
            reg_rdata = {filt_mask, filt_id};
    end
endmodule

// File: rtl/mcm_checker.sv
`timescale 1ns/1ps
module mcm_checker #(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr_en,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic                          wr_clr,
    input logic                          irq,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
    input mcm_pkg::run_state_t           run_state
);
    import mcm_pkg::*;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr_en) |=> $stable(cnt_val)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == RS_IDLE && !reg_wr_en) |=> $stable(cnt_val)); // R8

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt_val[0]) == {CNT_W{1'b1}} && cnt_val[0] == '0)); // R7

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_clr
        AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_addr == ADDR_W'(4 * k) && wr_clr) |=> (cnt_val[k] == '0)); // R9
    end
endmodule

bind mc_evt_monitor mcm_checker #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .wr_clr   (reg_wdata[1]),
    .irq      (irq),
    .cnt_val  (cnt_val),
    .run_state(run_state)
);

// File: tb/mc_evt_monitor_test.sv
`timescale 1ns/1ps
module mc_evt_monitor_test;
    localparam int CW = 8;
    localparam int NE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NE-1:0] evt_pulse = '0;
    logic          txn_rd_valid = 1'b0;
    logic [15:0]   txn_rd_id = '0;
    logic          txn_wr_valid = 1'b0;
    logic [15:0]   txn_wr_id = '0;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mc_evt_monitor #(.NUM_CNT(4), .CNT_W(CW), .NUM_EVT(NE), .ADDR_W(8), .ID_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .txn_rd_valid(txn_rd_valid), .txn_rd_id(txn_rd_id),
        .txn_wr_valid(txn_wr_valid), .txn_wr_id(txn_wr_id), .irq(irq)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    function automatic bit patt(int t, int j);
        return ((t * (j + 3) + j) % 7) < 3;
    endfunction

    function automatic bit id_ok(logic [15:0] id, logic [15:0] fid, logic [15:0] m);
        return ((id ^ fid) & ~m) == 16'h0;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v0;
        int e1, e2, e3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 map
        for (int n = 0; n < 4; n++) begin
            chk_reg("R1 ctrl reset", 8'(4 * n), 32'h0);
            chk_reg("R1 value reset", 8'(32 + 4 * n), 32'h0);
        end
        chk_reg("R1 filter reset", 8'h30, 32'h0);
        chk_reg("R2 unmapped offset", 8'h3C, 32'h0);
        check("R1 irq reset", 32'(irq), 32'h0);

        // R3 cycle counter, select discarded
        wr(8'h00, 32'h5500_0006);
        repeat (10) @(negedge clk);
        chk_reg("R3 cycle count", 8'h20, 32'd10);
        chk_reg("R3 sel ignored", 8'h00, 32'h0000_0004);

        // R4 selectable events, sweep three counters
        wr(8'h00, 32'h0000_0006);
        wr(8'h04, 32'h0300_0006);
        wr(8'h08, 32'h1100_0006);
        wr(8'h0C, 32'h3F00_0006);
        chk_reg("R2 ctrl readback", 8'h08, 32'h1100_0004);
        e1 = 0; e2 = 0; e3 = 0;
        for (int t = 0; t < 150; t++) begin
            for (int j = 0; j < NE; j++) evt_pulse[j] = patt(t, j);
            e1 += int'(patt(t, 3)); e2 += int'(patt(t, 17)); e3 += int'(patt(t, 63));
            @(negedge clk);
        end
        evt_pulse = '0;
        chk_reg("R4 counter1 sel3", 8'h24, 32'(e1));
        chk_reg("R4 counter2 sel17", 8'h28, 32'(e2));
        chk_reg("R4 counter3 sel63", 8'h2C, 32'(e3));

        // R4 unimplemented code counts nothing
        wr(8'h00, 32'h0000_0006);
        wr(8'h08, 32'h7000_0006);
        evt_pulse = '1;
        repeat (20) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R4 unimplemented code", 8'h28, 32'h0);

        // R5 ID filter sweep
        wr(8'h00, 32'h0000_0006);
        wr(8'h30, 32'h0005_0012);
        chk_reg("R2 filter readback", 8'h30, 32'h0005_0012);
        wr(8'h04, 32'h4100_0006);
        wr(8'h08, 32'h4200_0006);
        e1 = 0; e2 = 0;
        evt_pulse = '1;
        for (int t = 0; t < 64; t++) begin
            txn_rd_id = 16'(t) ^ ((t >= 32) ? 16'h0100 : 16'h0);
            txn_wr_id = 16'(t ^ 1);
            txn_rd_valid = (t % 3) != 0;
            txn_wr_valid = (t % 2) == 0;
            if (txn_rd_valid && id_ok(txn_rd_id, 16'h0012, 16'h0005)) e1++;
            if (txn_wr_valid && id_ok(txn_wr_id, 16'h0012, 16'h0005)) e2++;
            @(negedge clk);
        end
        txn_rd_valid = 1'b0; txn_wr_valid = 1'b0; evt_pulse = '0;
        chk_reg("R5 read filter count", 8'h24, 32'(e1));
        chk_reg("R5 write filter count", 8'h28, 32'(e2));
        wr(8'h30, 32'hFFFF_0000);
        wr(8'h00, 32'h0000_0006);
        for (int t = 0; t < 16; t++) begin
            txn_rd_id = 16'(t * 911); txn_rd_valid = 1'b1;
            txn_wr_id = 16'(t * 77); txn_wr_valid = (t < 5);
            @(negedge clk);
        end
        txn_rd_valid = 1'b0; txn_wr_valid = 1'b0;
        chk_reg("R5 all dont-care read", 8'h24, 32'(e1 + 16));
        chk_reg("R5 all dont-care write", 8'h28, 32'(e2 + 5));

        // R6 general counter wraps quietly, R9 ovf clear on write
        wr(8'h00, 32'h0000_0006);
        wr(8'h0C, 32'h0700_0006);
        evt_pulse[7] = 1'b1;
        repeat (200) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R6 pre-wrap count", 8'h2C, 32'd200);
        wr(8'h00, 32'h0000_0006);
        evt_pulse[7] = 1'b1;
        repeat (60) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R6 wrapped value", 8'h2C, 32'd4);
        chk_reg("R6 sticky ovf", 8'h0C, 32'h0700_0005);
        check("R6 no irq", 32'(irq), 32'h0);
        wr(8'h0C, 32'h0700_0004);
        chk_reg("R9 ovf cleared by write", 8'h0C, 32'h0700_0004);
        chk_reg("R9 value kept without clear", 8'h2C, 32'd4);

        // R8 disable cycle counter halts all
        wr(8'h00, 32'h0000_0006);
        wr(8'h04, 32'h0500_0006);
        evt_pulse[5] = 1'b1;
        repeat (10) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R8 counted before halt", 8'h24, 32'd10);
        wr(8'h00, 32'h0000_0000);
        rd(8'h20, v0);
        evt_pulse = '1;
        repeat (20) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R8 event counter halted", 8'h24, 32'd10);
        chk_reg("R8 cycle counter halted", 8'h20, v0);
        chk_reg("R8 ctrl0 disabled", 8'h00, 32'h0);
        wr(8'h00, 32'h0000_0004);
        evt_pulse[5] = 1'b1;
        repeat (10) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R8 resume from held value", 8'h24, 32'd20);
        chk_reg("R9 re-enable zeroes cycle counter", 8'h20, 32'd10);

        // R7 cycle overflow freezes, R10 state transitions
        wr(8'h04, 32'h0900_0006);
        wr(8'h00, 32'h0000_0006);
        for (int t = 0; t < 255; t++) begin
            evt_pulse[9] = (t % 2) == 0;
            @(negedge clk);
        end
        check("R7 no irq before wrap", 32'(irq), 32'h0);
        chk_reg("R7 cycle at max", 8'h20, 32'd255);
        for (int t = 255; t < 300; t++) begin
            evt_pulse[9] = (t % 2) == 0;
            @(negedge clk);
        end
        evt_pulse = '0;
        check("R7 irq raised", 32'(irq), 32'h1);
        chk_reg("R7 cycle wrapped", 8'h20, 32'd0);
        chk_reg("R7 ctrl0 ovf", 8'h00, 32'h0000_0005);
        chk_reg("R10 frozen event counter", 8'h24, 32'd128);
        wr(8'h00, 32'h0000_0004);
        check("R7 irq cleared", 32'(irq), 32'h0);
        chk_reg("R10 ctrl0 after rearm", 8'h00, 32'h0000_0004);
        evt_pulse[9] = 1'b1;
        repeat (5) @(negedge clk);
        evt_pulse = '0;
        chk_reg("R10 resumed from frozen", 8'h24, 32'd133);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule